// File: doc/BRIEF.md
# I2C Master SCL Bit-Slot Timer

This block times the bit slots of an I2C master. From one prescaler tick (a single-cycle enable pulse made by an external divider) it runs SCL through a fixed cycle of phases: a data-hold wait after each falling edge, then a "change SDA now" strobe, a programmable low period, a programmable data-setup wait, and then SCL is released. Once the released line actually reads high it counts the high period and pulls SCL low again. SCL is open-drain, so the block only requests a pull-down. A slave that holds the line low stretches the low phase, because the high count does not start until the line is seen high.

In every bit slot, the SDA-change strobe tells the byte logic when it may move SDA. The sample strobe tells it when to capture SDA. Start/stop framing, shifting, addressing and arbitration belong to the surrounding master. All delays are counted in prescaler ticks. Settings are meant to be changed only while the enable is low.

Top module: `sclSlotTimer`

## Requirements
- R1: While `enable` is low, `sclPullLow` is 0 and `sdaChange` is 0 from the next cycle on, and `sdaSample` is 0. On the first cycle with `enable` high, the block behaves as if a falling edge had just occurred.
- R2: After each falling edge (`sclPullLow` going to 1), SCL stays pulled low for `holdTicks` ticks before `sdaChange` pulses. With `holdTicks` = 0 the pulse comes in the first cycle that SCL is low.
- R3: `sdaChange` is a single-cycle pulse, issued once per bit slot, and only while SCL is pulled low.
- R4: After the `sdaChange` pulse, SCL stays low for `lowTicks`+1 further ticks.
- R5: After the low period, SCL stays low for `setupTicks`+1 further ticks, and then `sclPullLow` drops to 0.
- R6: The SCL line input passes through a two-flop synchronizer. The high period begins only in the cycle after the synchronized line reads 1. While another device holds the line low, the block waits with SCL released.
- R7: The high period lasts `highTicks`+1 ticks, after which `sclPullLow` returns to 1.
- R8: `sdaSample` is high for exactly one cycle per slot: the cycle of the first tick of the high period, while SCL is released.
- R9: Phase counters advance only in cycles where `tick` is 1. With no tick, every counting phase holds.
- R10: Reset (`rstN` low) puts the block in the disabled state with both synchronizer flops at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the bit-slot sequence; low releases SCL and clears counters |
| tick | input | 1 | One-cycle prescaler enable pulse |
| lowTicks | input | 8 | Low period setting, length lowTicks+1 ticks |
| highTicks | input | 8 | High period setting, length highTicks+1 ticks |
| holdTicks | input | 4 | Data-hold wait after falling edge, in ticks (0 = none) |
| setupTicks | input | 4 | Data-setup wait before release, length setupTicks+1 ticks |
| sclLineIn | input | 1 | Observed level of the SCL wire |
| sclPullLow | output | 1 | 1 = drive SCL low, 0 = release (open drain) |
| sdaChange | output | 1 | One-cycle strobe: SDA may change now |
| sdaSample | output | 1 | One-cycle strobe: sample SDA now |

## Verification
The embedded assertions check the following on every cycle: SCL is released one cycle after the enable drops, the change strobe is a lone pulse that occurs only while SCL is low, the sample strobe occurs only while SCL is released, and the phase counter stays still in tickless cycles unless it is being cleared. The exact tick counts of the hold, low, setup and high phases cannot be checked by these assertions. Neither can the wait for a stretched line or the restart after a mid-slot disable. Those only show up in the bench's comparison against its behavioural model across several tick rates, settings and stretch patterns.

// File: rtl/sclSlotPkg.sv
package sclSlotPkg;
  localparam int CNT_W = 8;
  localparam int DLY_W = 4;

  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_HOLD  = 3'd1,
    PH_LOW   = 3'd2,
    PH_SETUP = 3'd3,
    PH_WAITH = 3'd4,
    PH_HIGH  = 3'd5
  } slotPhase_t;

  typedef struct packed {
    logic       clr;
    logic       inc;
    slotPhase_t phase;
  } ctrlStrobe_t;

  typedef struct packed {
    logic lastTick;
    logic firstTick;
    logic lineHigh;
  } dpStatus_t;
endpackage

// File: rtl/sclSlotDatapath.sv
module sclSlotDatapath
  import sclSlotPkg::*;
#(
  parameter int CntW = CNT_W,
  parameter int DlyW = DLY_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [CntW-1:0] lowTicks,
  input  logic [CntW-1:0] highTicks,
  input  logic [DlyW-1:0] holdTicks,
  input  logic [DlyW-1:0] setupTicks,
  input  logic            sclLineIn,
  input  ctrlStrobe_t     ctrl,
  output dpStatus_t       status
);
  localparam logic [CntW-1:0] ONE = CntW'(1);

  logic [CntW-1:0] cnt;
  logic [CntW-1:0] limit;
  logic            syncA;
  logic            syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= sclLineIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    unique case (ctrl.phase)
      PH_HOLD:  limit = CntW'(holdTicks) - ONE;
      PH_LOW:   limit = lowTicks;
      PH_SETUP: limit = CntW'(setupTicks);
      PH_HIGH:  limit = highTicks;
      default:  limit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (ctrl.clr) cnt <= '0;
    else if (ctrl.inc) cnt <= cnt + ONE;
  end

  assign status.lastTick  = tick && (cnt == limit);
  assign status.firstTick = tick && (cnt == '0);
  assign status.lineHigh  = syncB;

  assert_cnt_still_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctrl.clr) |=> $stable(cnt));
endmodule

// File: rtl/sclSlotControl.sv
module sclSlotControl
  import sclSlotPkg::*;
#(
  parameter int DlyW = DLY_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            tick,
  input  logic [DlyW-1:0] holdTicks,
  input  dpStatus_t       status,
  output ctrlStrobe_t     ctrl,
  output logic            sclPullLow,
  output logic            sdaChange,
  output logic            sdaSample
);
  slotPhase_t state, stateNxt;
  logic       chgNxt;
  logic       holdZero;
  logic       counting;

  assign holdZero = (holdTicks == '0);
  assign counting = (state == PH_HOLD) || (state == PH_LOW) ||
                    (state == PH_SETUP) || (state == PH_HIGH);

  always_comb begin
    stateNxt = state;
    chgNxt   = 1'b0;
    ctrl.clr = 1'b0;
    ctrl.inc = 1'b0;
    if (!enable) begin
      stateNxt = PH_OFF;
      ctrl.clr = 1'b1;
    end else begin
      unique case (state)
        PH_OFF: begin
          stateNxt = holdZero ? PH_LOW : PH_HOLD;
          chgNxt   = holdZero;
          ctrl.clr = 1'b1;
        end
        PH_WAITH: begin
          ctrl.clr = 1'b1;
          if (status.lineHigh) stateNxt = PH_HIGH;
        end
        default: begin
          if (counting && status.lastTick) begin
            ctrl.clr = 1'b1;
            unique case (state)
              PH_HOLD:  begin stateNxt = PH_LOW; chgNxt = 1'b1; end
              PH_LOW:   stateNxt = PH_SETUP;
              PH_SETUP: stateNxt = PH_WAITH;
              default: begin
                stateNxt = holdZero ? PH_LOW : PH_HOLD;
                chgNxt   = holdZero;
              end
            endcase
          end else if (counting && tick) begin
            ctrl.inc = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PH_OFF;
      sdaChange <= 1'b0;
    end else begin
      state     <= stateNxt;
      sdaChange <= chgNxt;
    end
  end

  assign ctrl.phase = state;
  assign sclPullLow = (state == PH_HOLD) || (state == PH_LOW) || (state == PH_SETUP);
  assign sdaSample  = (state == PH_HIGH) && status.firstTick;

  assert_off_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclPullLow && !sdaChange));
  assert_change_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    sdaChange |=> !sdaChange);
  assert_change_while_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    sdaChange |-> sclPullLow);
  assert_sample_released_R8: assert property (@(posedge clk) disable iff (!rstN)
    sdaSample |-> !sclPullLow);
endmodule

// File: rtl/sclSlotTimer.sv
module sclSlotTimer
  import sclSlotPkg::*;
#(
  parameter int CntW = CNT_W,
  parameter int DlyW = DLY_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            tick,
  input  logic [CntW-1:0] lowTicks,
  input  logic [CntW-1:0] highTicks,
  input  logic [DlyW-1:0] holdTicks,
  input  logic [DlyW-1:0] setupTicks,
  input  logic            sclLineIn,
  output logic            sclPullLow,
  output logic            sdaChange,
  output logic            sdaSample
);
  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  sclSlotDatapath #(.CntW(CntW), .DlyW(DlyW)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .lowTicks(lowTicks), .highTicks(highTicks),
    .holdTicks(holdTicks), .setupTicks(setupTicks),
    .sclLineIn(sclLineIn), .ctrl(ctrl), .status(status)
  );

  sclSlotControl #(.DlyW(DlyW)) ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .holdTicks(holdTicks), .status(status), .ctrl(ctrl),
    .sclPullLow(sclPullLow), .sdaChange(sdaChange), .sdaSample(sdaSample)
  );
endmodule

// File: tb/sclSlotTimer_tb.sv
module sclSlotTimer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] lowTicks = 8'd3;
  logic [7:0] highTicks = 8'd2;
  logic [3:0] holdTicks = 4'd1;
  logic [3:0] setupTicks = 4'd0;
  logic       slaveHold = 1'b0;
  logic       sclPullLow, sdaChange, sdaSample;
  logic       sclLine;

  int checks = 0;
  int failures = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  logic [7:0] lfsr = 8'hA5;
  int samplesSeen = 0;
  int changesSeen = 0;

  // behavioural model state
  int   mPhase = 0;   // 0 off,1 hold,2 low,3 setup,4 wait-high,5 high
  int   mRem = 0;
  logic mChg = 1'b0;
  logic mS1 = 1'b0, mS2 = 1'b0;
  logic mPull, mSample;

  always #10 clk = ~clk;

  assign sclLine = ~sclPullLow & ~slaveHold;

  sclSlotTimer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .lowTicks(lowTicks), .highTicks(highTicks),
    .holdTicks(holdTicks), .setupTicks(setupTicks),
    .sclLineIn(sclLine), .sclPullLow(sclPullLow),
    .sdaChange(sdaChange), .sdaSample(sdaSample)
  );

  assign mPull   = (mPhase >= 1) && (mPhase <= 3);
  assign mSample = (mPhase == 5) && tick && (mRem == int'(highTicks) + 1);

  task automatic fallEdge();
    if (holdTicks == 0) begin mPhase = 2; mRem = int'(lowTicks) + 1; mChg = 1'b1; end
    else begin mPhase = 1; mRem = int'(holdTicks); end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mRem = 0; mChg = 1'b0; mS1 = 1'b0; mS2 = 1'b0;
    end else begin
      logic lineNow, oldS2;
      lineNow = ~mPull & ~slaveHold;
      oldS2 = mS2;
      mS2 = mS1; mS1 = lineNow;
      mChg = 1'b0;
      if (!enable) mPhase = 0;
      else case (mPhase)
        0: fallEdge();
        1: if (tick) begin mRem--; if (mRem == 0) begin mPhase = 2; mRem = int'(lowTicks) + 1; mChg = 1'b1; end end
        2: if (tick) begin mRem--; if (mRem == 0) begin mPhase = 3; mRem = int'(setupTicks) + 1; end end
        3: if (tick) begin mRem--; if (mRem == 0) mPhase = 4; end
        4: if (oldS2) begin mPhase = 5; mRem = int'(highTicks) + 1; end
        default: if (tick) begin mRem--; if (mRem == 0) fallEdge(); end
      endcase
    end
  end

  function automatic string phaseTag(int p);
    case (p)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // tick generator, driven at negedge
  always @(negedge clk) begin
    if (tickDiv == 0) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick <= lfsr[0];
    end else begin
      tickCnt = (tickCnt + 1) % tickDiv;
      tick <= (tickCnt == 0);
    end
  end

  // per-cycle comparison, away from edges
  always begin
    @(negedge clk); #5;
    if (rstN) begin
      check(phaseTag(mPhase), sclPullLow, mPull, "sclPullLow");
      check((mPhase == 0) ? "R1" : "R3", sdaChange, mChg, "sdaChange");
      check(tick ? "R8" : "R9", sdaSample, mSample, "sdaSample");
      if (sdaSample) samplesSeen++;
      if (sdaChange) changesSeen++;
    end
  end

  task automatic runCfg(int l, int h, int hd, int su, int div, int cycles);
    @(negedge clk);
    enable <= 1'b0;
    @(negedge clk);
    lowTicks <= 8'(l); highTicks <= 8'(h); holdTicks <= 4'(hd); setupTicks <= 4'(su);
    tickDiv = div;
    @(negedge clk);
    enable <= 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #1;
    check("R10", sclPullLow, 1'b0, "reset sclPullLow");
    check("R10", sdaChange, 1'b0, "reset sdaChange");
    repeat (3) @(negedge clk);
    rstN <= 1'b1;
    repeat (2) @(negedge clk);
    #5;
    check("R1", sclPullLow, 1'b0, "disabled sclPullLow");
    check("R1", sdaSample, 1'b0, "disabled sdaSample");

    runCfg(3, 2, 1, 0, 1, 300);      // fast ticks
    runCfg(5, 4, 0, 2, 3, 600);      // zero hold (R2)
    runCfg(0, 0, 0, 0, 1, 200);      // minimum settings
    runCfg(2, 3, 15, 15, 2, 900);    // maximum delays
    runCfg(4, 1, 2, 1, 0, 1500);     // irregular ticks (R9)

    // slave stretching (R6)
    runCfg(2, 2, 1, 1, 2, 20);
    repeat (10) begin
      @(negedge clk);
      wait (mPhase == 4 || sclPullLow == 1'b0);
      slaveHold <= 1'b1;
      repeat (17) @(negedge clk);
      #5;
      check("R6", sdaSample, 1'b0, "no sample during stretch");
      slaveHold <= 1'b0;
      repeat (40) @(negedge clk);
    end

    // mid-slot disable then restart (R1)
    runCfg(6, 6, 3, 3, 2, 37);
    enable <= 1'b0;
    @(negedge clk); #5;
    check("R1", sclPullLow, 1'b0, "released after disable");
    @(negedge clk);
    enable <= 1'b1;
    repeat (300) @(negedge clk);

    checks++;
    if (samplesSeen < 20) begin failures++; $display("FAIL R8 samples actual=%0d expected>=20", samplesSeen); end
    checks++;
    if (changesSeen < 20) begin failures++; $display("FAIL R3 changes actual=%0d expected>=20", changesSeen); end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule